// File: doc/BRIEF.md
# Shared-Memory Bitstream Fetch Arbiter

This block streams a configuration image, one 32-bit word at a time, from a single-port synchronous memory into a configuration write port. Application logic uses the same memory port. Software or a controller programs the block through a small command port. It loads a start address and a word count, then issues a go command. The block then fetches words in ascending address order and delivers each one to the configuration port with a one-cycle strobe.

On every cycle the memory port serves at most one party. When the application and the fetcher both want the port, the grant alternates between them. When the fetcher is idle, the application is always granted. A transfer can therefore stall at any word boundary and pick up again later. Completion is tied to the number of words actually delivered, not to a fixed delay.

Top module: `bs_fetch_arb`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_wr`, `cmd_err` and `app_rvalid` are all 0.
- R2: Commands are decoded as follows: `cmd_op` 00 does nothing, 01 loads the start address from `cmd_arg`, 10 loads the word count from the low CNT_W bits of `cmd_arg`, and 11 starts a transfer. A start with a non-zero count raises `busy` in the next cycle and clears `done`.
- R3: During a transfer, the word from address start+i is delivered as the i-th `cfg_wr` beat, for i from 0 to count-1. Every word is delivered exactly once, even when application accesses interleave. `cfg_wr` is high only in the cycle after a fetcher read was issued.
- R4: `done` rises, and `busy` falls, in the cycle after the beat that brings the delivered count to the programmed count. `done` never rises earlier.
- R5: A start with a count of 0 sets `done` in the next cycle. `busy` is never raised and no `cfg_wr` beat appears.
- R6: While `busy` is high, any `cmd_op` other than 00 is ignored: the start address, the count and the running transfer are unchanged. `cmd_err` is high for exactly the one following cycle.
- R7: While no transfer is running, an application request is granted in the same cycle (`app_gnt` equals `app_req`).
- R8: While the fetcher has words left to fetch, an application request that was refused in one cycle is granted in the next cycle if it is still present. The application and the fetcher are never granted in the same cycle.
- R9: A granted application read returns its data on `app_rdata` with `app_rvalid` high exactly one cycle later. A granted write drives `mem_we` and never `mem_re` in the same cycle.
- R10: `done` stays high until the next accepted start with a non-zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command code (00 nop, 01 address, 10 count, 11 start) |
| cmd_arg | input | ARG_W | Command parameter |
| app_req | input | 1 | Application memory request |
| app_we | input | 1 | Application request is a write |
| app_addr | input | ADDR_W | Application memory address |
| app_wdata | input | DATA_W | Application write data |
| app_gnt | output | 1 | Application request accepted this cycle |
| app_rvalid | output | 1 | Application read data valid |
| app_rdata | output | DATA_W | Application read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_re` |
| cfg_data | output | DATA_W | Configuration word |
| cfg_wr | output | 1 | Configuration word strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer complete |
| cmd_err | output | 1 | One-cycle pulse: command refused while busy |

## Verification
The bench builds the block with a 32-bit address and data path, an 8-bit word counter and round-robin arbitration enabled. A 256-entry memory model backs the block. The narrow counter keeps image lengths short, so many complete transfers fit in one run. These include a zero-length start and back-to-back restarts. Bitstream images sit in the lower half of the memory model and random application traffic uses only the upper half. Each delivered word can therefore be checked against a known address while the application keeps stealing cycles from the fetcher.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
   typedef enum logic [1:0] {
      BSF_NOP      = 2'b00,
      BSF_SET_BASE = 2'b01,
      BSF_SET_LEN  = 2'b10,
      BSF_GO       = 2'b11
   } bsf_op_e;
endpackage

// File: rtl/bsf_cmd_regs.sv
module bsf_cmd_regs #(
   parameter int ARG_W  = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op,
   input  logic [ARG_W-1:0]  arg,
   input  logic              busy,
   output logic [ADDR_W-1:0] base_q,
   output logic [CNT_W-1:0]  len_q,
   output logic              go,
   output logic              cmd_err
);
   import bsf_pkg::*;

   initial begin
      assert (ADDR_W <= ARG_W) else $error("ADDR_W wider than ARG_W");
      assert (CNT_W  <= ARG_W) else $error("CNT_W wider than ARG_W");
   end

   logic accept;
   wire  unused_arg = ^arg;

   assign accept = !busy;
   assign go     = accept && (op == BSF_GO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         len_q   <= '0;
         cmd_err <= 1'b0;
      end else begin
         cmd_err <= busy && (op != BSF_NOP);
         if (accept && op == BSF_SET_BASE) base_q <= arg[ADDR_W-1:0];
         if (accept && op == BSF_SET_LEN)  len_q  <= arg[CNT_W-1:0];
      end
   end

   // R6: programmed values hold still while a transfer runs
   a_r6_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(base_q) && $stable(len_q)));
endmodule

// File: rtl/bsf_arbiter.sv
module bsf_arbiter #(
   parameter bit FAIR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic app_req,
   input  logic ldr_req,
   output logic app_gnt,
   output logic ldr_gnt
);
   generate
      if (FAIR) begin : g_rr
         logic last_app;
         always_comb begin
            app_gnt = app_req && (!ldr_req || !last_app);
            ldr_gnt = ldr_req && !app_gnt;
         end
         always_ff @(posedge clk) begin
            if (!rst_n)                  last_app <= 1'b0;
            else if (app_gnt || ldr_gnt) last_app <= app_gnt;
         end

         // R8: a refused application request wins the following cycle
         a_r8_rr_turn: assert property (@(posedge clk) disable iff (!rst_n)
            (app_req && !app_gnt) |=> (!app_req || app_gnt));
      end else begin : g_fixed
         always_comb begin
            app_gnt = app_req;
            ldr_gnt = ldr_req && !app_req;
         end
      end
   endgenerate

   // R8: never two owners of the memory port
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(app_gnt && ldr_gnt));
   // R7: an idle fetcher never blocks the application
   a_r7_idle_app: assert property (@(posedge clk) disable iff (!rst_n)
      (app_req && !ldr_req) |-> app_gnt);
endmodule

// File: rtl/bsf_stream.sv
module bsf_stream #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  len,
   input  logic              ldr_gnt,
   input  logic              rd_back,
   output logic              ldr_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              done
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= ADDR_W) else $error("CNT_W out of range");
   end

   logic [CNT_W-1:0] iss_cnt, dlv_cnt;
   logic             last_beat;

   assign ldr_req   = busy && (iss_cnt != len);
   assign rd_addr   = base + ADDR_W'(iss_cnt);
   assign last_beat = rd_back && ((dlv_cnt + 1'b1) == len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iss_cnt <= '0;
         dlv_cnt <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else if (go) begin
         iss_cnt <= '0;
         dlv_cnt <= '0;
         busy    <= (len != '0);
         done    <= (len == '0);
      end else begin
         if (ldr_gnt) iss_cnt <= iss_cnt + 1'b1;
         if (rd_back) dlv_cnt <= dlv_cnt + 1'b1;
         if (last_beat) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   // R4: completion only once the delivered count matches
   a_r4_done_at_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (dlv_cnt == len));
   // R5: an empty image never makes the block busy
   a_r5_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (len != '0));
   // R3: deliveries never run ahead of fetches
   a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (dlv_cnt <= iss_cnt));
endmodule

// File: rtl/bs_fetch_arb.sv
module bs_fetch_arb #(
   parameter int ARG_W  = 32,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter bit FAIR   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [ARG_W-1:0]  cmd_arg,
   input  logic              app_req,
   input  logic              app_we,
   input  logic [ADDR_W-1:0] app_addr,
   input  logic [DATA_W-1:0] app_wdata,
   output logic              app_gnt,
   output logic              app_rvalid,
   output logic [DATA_W-1:0] app_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] cfg_data,
   output logic              cfg_wr,
   output logic              busy,
   output logic              done,
   output logic              cmd_err
);
   logic [ADDR_W-1:0] base_q, rd_addr;
   logic [CNT_W-1:0]  len_q;
   logic              go, ldr_req, ldr_gnt;
   logic              app_rd_q, ldr_rd_q;

   bsf_cmd_regs #(.ARG_W(ARG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .op(cmd_op), .arg(cmd_arg), .busy(busy),
      .base_q(base_q), .len_q(len_q), .go(go), .cmd_err(cmd_err)
   );

   bsf_arbiter #(.FAIR(FAIR)) u_arb (
      .clk(clk), .rst_n(rst_n), .app_req(app_req), .ldr_req(ldr_req),
      .app_gnt(app_gnt), .ldr_gnt(ldr_gnt)
   );

   bsf_stream #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stream (
      .clk(clk), .rst_n(rst_n), .go(go), .base(base_q), .len(len_q),
      .ldr_gnt(ldr_gnt), .rd_back(ldr_rd_q), .ldr_req(ldr_req),
      .rd_addr(rd_addr), .busy(busy), .done(done)
   );

   assign mem_addr  = app_gnt ? app_addr : rd_addr;
   assign mem_wdata = app_wdata;
   assign mem_we    = app_gnt && app_we;
   assign mem_re    = ldr_gnt || (app_gnt && !app_we);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         app_rd_q <= 1'b0;
         ldr_rd_q <= 1'b0;
      end else begin
         app_rd_q <= app_gnt && !app_we;
         ldr_rd_q <= ldr_gnt;
      end
   end

   assign app_rvalid = app_rd_q;
   assign app_rdata  = mem_rdata;
   assign cfg_wr     = ldr_rd_q;
   assign cfg_data   = mem_rdata;

   // R3: each configuration beat answers a read issued one cycle before
   a_r3_beat_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> $past(mem_re));
   // R9: one memory operation per cycle
   a_r9_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));
   // R9: application read data arrives after a read was issued
   a_r9_app_latency: assert property (@(posedge clk) disable iff (!rst_n)
      app_rvalid |-> $past(mem_re));
   // R6: error pulse follows a refused command
   a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> ($past(busy) && ($past(cmd_op) != 2'b00)));
   // R3: configuration strobe and application data never share a cycle
   a_r3_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_wr, app_rvalid}));
endmodule

// File: tb/bs_fetch_arb_tb_top.sv
`timescale 1ns/1ps
module bs_fetch_arb_tb_top;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [31:0] cmd_arg = '0;
   logic app_req = 1'b0, app_we = 1'b0;
   logic [ADDR_W-1:0] app_addr = '0;
   logic [DATA_W-1:0] app_wdata = '0;
   logic app_gnt, app_rvalid, mem_we, mem_re, cfg_wr, busy, done, cmd_err;
   logic [DATA_W-1:0] app_rdata, mem_wdata, mem_rdata, cfg_data;
   logic [ADDR_W-1:0] mem_addr;

   always #2 clk = ~clk;

   bs_fetch_arb #(.ARG_W(32), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FAIR(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .app_req(app_req), .app_we(app_we), .app_addr(app_addr), .app_wdata(app_wdata),
      .app_gnt(app_gnt), .app_rvalid(app_rvalid), .app_rdata(app_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .cfg_data(cfg_data), .cfg_wr(cfg_wr),
      .busy(busy), .done(done), .cmd_err(cmd_err)
   );

   logic [31:0] ram [256];
   logic [31:0] rdq = '0;
   assign mem_rdata = rdq;
   always @(posedge clk) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) rdq <= ram[mem_addr[7:0]];
   end

   int n_chk = 0, n_err = 0;
   int exp_base = 0, exp_len = 0, exp_idx = 0;
   bit rv_pend = 1'b0;
   logic [31:0] rv_data = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] img_word(input int a);
      return 32'hC0DE_0000 ^ (a * 32'h0101_0107);
   endfunction

   // monitor: samples away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (app_rvalid !== rv_pend) chk(1'b0, "R9 rvalid", {31'b0, app_rvalid}, {31'b0, rv_pend});
         else if (rv_pend) chk(app_rdata == rv_data, "R9 read data", app_rdata, rv_data);
         rv_pend = 1'b0;
         if (cfg_wr) begin
            if (exp_idx >= exp_len) chk(1'b0, "R3 extra beat", exp_idx, exp_len);
            else chk(cfg_data == img_word(exp_base + exp_idx), "R3 word order", cfg_data, img_word(exp_base + exp_idx));
            exp_idx++;
         end
      end
   end

   task automatic tick(input logic [1:0] op, input logic [31:0] arg, input bit req, input bit we,
                       input logic [7:0] a, input logic [31:0] wd, output bit g);
      @(negedge clk);
      cmd_op = op; cmd_arg = arg; app_req = req; app_we = we;
      app_addr = {24'h0, a}; app_wdata = wd;
      #1;
      g = req && app_gnt;
      if (g && !we) begin
         rv_pend = 1'b1;
         rv_data = ram[a];
      end
   endtask

   task automatic rtick(input logic [1:0] op, input logic [31:0] arg, input bit traffic, output bit g);
      bit r;
      r = traffic ? bit'($urandom % 2) : 1'b0;
      tick(op, arg, r, bit'($urandom % 2), 8'(128 + $urandom % 128), $urandom, g);
   endtask

   task automatic run_xfer(input int base, input int len, input bit traffic);
      bit g;
      rtick(2'b01, base, traffic, g);
      rtick(2'b10, len, traffic, g);
      exp_base = base; exp_len = len; exp_idx = 0;
      rtick(2'b11, 0, traffic, g);
      rtick(2'b00, 0, traffic, g);
      if (len == 0) begin
         chk(done == 1'b1, "R5 empty done", done, 1);
         chk(busy == 1'b0, "R5 empty not busy", busy, 0);
      end else begin
         chk(busy == 1'b1, "R2 busy after start", busy, 1);
         chk(done == 1'b0, "R10 done cleared by start", done, 0);
      end
      for (int i = 0; i < 2000 && !done; i++) begin
         chk(!done || exp_idx == exp_len, "R4 early done", exp_idx, exp_len);
         rtick(2'b00, 0, traffic, g);
      end
      chk(exp_idx == exp_len, "R4 count at done", exp_idx, exp_len);
      chk(busy == 1'b0, "R4 busy cleared", busy, 0);
      for (int i = 0; i < 3; i++) rtick(2'b00, 0, traffic, g);
      chk(done == 1'b1, "R10 done held", done, 1);
      chk(exp_idx == exp_len, "R3 no extra words", exp_idx, exp_len);
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      bit g, prev_denied;
      int start_idx;
      void'($urandom(32'h5EED));
      for (int i = 0; i < 256; i++) ram[i] = img_word(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0, "R1 busy/done reset", {busy, done}, 0);
      chk(cfg_wr == 0 && cmd_err == 0 && app_rvalid == 0, "R1 strobes reset", {cfg_wr, cmd_err, app_rvalid}, 0);

      // R7: idle fetcher, application granted at once
      for (int i = 0; i < 4; i++) begin
         tick(2'b00, 0, 1'b1, i[0], 8'(130 + i), 32'hABCD_0000 + i, g);
         chk(g == 1'b1, "R7 idle grant", g, 1);
      end
      tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);

      // R2/R3/R4 plain transfer, no traffic
      run_xfer(10, 5, 1'b0);
      // R5 zero length
      run_xfer(30, 0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);
         chk(busy == 0 && exp_idx == 0, "R5 no beats", exp_idx, 0);
      end

      // R6 commands while busy
      tick(2'b01, 20, 1'b0, 1'b0, 8'd0, 0, g);
      tick(2'b10, 6, 1'b0, 1'b0, 8'd0, 0, g);
      exp_base = 20; exp_len = 6; exp_idx = 0;
      tick(2'b11, 0, 1'b0, 1'b0, 8'd0, 0, g);
      tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);
      chk(cmd_err == 0, "R6 no error on nop", cmd_err, 0);
      tick(2'b01, 90, 1'b0, 1'b0, 8'd0, 0, g);
      tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);
      chk(cmd_err == 1, "R6 error pulse", cmd_err, 1);
      tick(2'b11, 0, 1'b0, 1'b0, 8'd0, 0, g);
      chk(cmd_err == 0, "R6 error one cycle", cmd_err, 0);
      tick(2'b10, 2, 1'b0, 1'b0, 8'd0, 0, g);
      chk(cmd_err == 1, "R6 refused start errs", cmd_err, 1);
      for (int i = 0; i < 100 && !done; i++) tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);
      chk(exp_idx == 6, "R6 count unchanged", exp_idx, 6);

      // R8 contention: application requests every cycle
      tick(2'b01, 40, 1'b0, 1'b0, 8'd0, 0, g);
      tick(2'b10, 10, 1'b0, 1'b0, 8'd0, 0, g);
      exp_base = 40; exp_len = 10; exp_idx = 0;
      tick(2'b11, 0, 1'b0, 1'b0, 8'd0, 0, g);
      prev_denied = 1'b0;
      start_idx = exp_idx;
      for (int i = 0; i < 12; i++) begin
         tick(2'b00, 0, 1'b1, 1'b0, 8'd200, 0, g);
         chk(!(prev_denied && !g), "R8 alternating grant", g, 1);
         prev_denied = !g;
      end
      chk(exp_idx > start_idx, "R8 fetcher progresses", exp_idx, start_idx + 1);
      for (int i = 0; i < 100 && !done; i++) tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);
      chk(exp_idx == 10, "R8 resumed complete", exp_idx, 10);

      // random transfers with random application traffic
      for (int t = 0; t < 25; t++) begin
         run_xfer(int'($urandom % 100), int'(1 + $urandom % 24), 1'b1);
         rtick(2'b00, 0, 1'b1, g);
         chk(g == app_req, "R7 idle grant random", g, app_req);
      end
      run_xfer(64, 63, 1'b1);

      tick(2'b00, 0, 1'b0, 1'b0, 8'd0, 0, g);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule